// File: doc/BRIEF.md
# Parallel LCD Bus Host Engine

This block drives an 8080-style parallel bus toward an LCD controller for an upstream controller. A request is one of three operations: write an 8-bit command, write a 16-bit data word, or read a multi-byte identification value. The block produces chip select, a register-select line, active-low write and read strobes, and the 16-bit data word with an output enable. It returns a busy/done handshake and the assembled identification.

Each bus cycle has three parts: an address-setup phase, a strobe phase and one hold cycle. The lengths of the setup and strobe phases come from two configuration inputs, each 15 cycles in the usual setting. An identification read writes a fixed command, discards one dummy read, and then packs the low byte of each later read into the result, first byte in the most significant position. A result of 0x040404 raises a no-display flag.

Top module: `pbus_host`

## Requirements
- R1: While reset is held and on leaving it, chip select, both strobes and register-select sit inactive (cs_n, wr_n, rd_n = 1), the output enable is 0, and busy, done, rd_value and no_display are all 0.
- R2: Operation code 2'b00 writes a command. It makes one write-strobe bus cycle with lcd_rs = 0 and the bus carrying {8'h00, req_wdata[7:0]}, so the upper request bits are ignored.
- R3: Operation code 2'b01 writes data. It makes one write-strobe bus cycle with lcd_rs = 1 and the bus carrying all 16 bits of req_wdata.
- R4: Each bus cycle has an address phase of A cycles with chip select low and both strobes high, a strobe phase of D cycles with one strobe low, and one hold cycle with the strobe high and written data still driven. A and D are cfg_addr_setup and cfg_data_setup, and a value of 0 counts as 1. A transaction of n bus cycles keeps busy high for n*(A+D+1) cycles.
- R5: Operation code 2'b10 reads the identification. It writes command 0x04 with lcd_rs = 0, then makes one dummy read, then N reads, all reads with lcd_rs = 1, for N+2 bus cycles in total.
- R6: The dummy read is discarded. The identification starts at zero, and each later read shifts it left by 8 and ORs in bus bits [7:0], so the first byte read ends up most significant.
- R7: N equals req_nbytes when that is between 1 and MAX_ID_BYTES (4). A value of 0 or above the maximum gives N = 3.
- R8: During every cycle of a read bus cycle the output enable is 0. Read data is sampled only on the last cycle of the read strobe.
- R9: A request is taken only while busy is low, and a request raised while busy is ignored. done is high for exactly one cycle after the last hold cycle, and busy is low in that cycle.
- R10: Chip select stays low without a break from the first address phase to the last hold cycle of a transaction, including between the bus cycles of an identification read.
- R11: At the end of each identification read, no_display becomes 1 if the result equals 0x040404 and 0 otherwise. Command and data writes leave no_display and rd_value unchanged.
- R12: Operation code 2'b11 is reserved. A request with it starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_op | input | 2 | 00 command, 01 data, 10 identification read, 11 reserved |
| req_wdata | input | 16 | Command byte in bits [7:0], or data word |
| req_nbytes | input | 3 | Identification byte count (0 gives the default) |
| cfg_addr_setup | input | 4 | Address-setup length in cycles |
| cfg_data_setup | input | 4 | Strobe length in cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_value | output | 32 | Packed identification |
| no_display | output | 1 | Identification equalled 0x040404 |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_d_o | output | 16 | Bus value driven toward the display |
| lcd_d_oe | output | 1 | Bus output enable (0 = released) |
| lcd_d_i | input | 8 | Bus bits [7:0] as seen from the display |

## Verification
All three operations are swept across a grid of setup and strobe lengths, including the zero-counts-as-one setting and the 15/15 setting. Cycle counts of chip select, write strobe, read strobe and output enable separate address, strobe and hold timing faults from faults in sequencing. Commands carry a nonzero upper byte, which catches a missing zero-extension. The display model drives a decoy value on every strobe cycle except the last, and puts a different marker in each read's upper byte, so sampling on the wrong cycle, packing in the wrong order or keeping the dummy read each give a wrong identification. Requests raised while busy, the reserved code, out-of-range byte counts and the 0x040404 pattern cover the handshake and flag corner cases.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   typedef enum logic [1:0] {
      OP_CMD  = 2'b00,
      OP_DATA = 2'b01,
      OP_ID   = 2'b10,
      OP_RSV  = 2'b11
   } pbus_op_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD
   } pbus_phase_e;
endpackage

// File: rtl/pbus_timer.sv
// Phase length counter: after load, last is high in the L-th cycle (L = max(val,1)).
module pbus_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pbus_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= (load_val == '0) ? CNT_W'(1) : load_val;
      else if (cnt_q > CNT_W'(1))
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign last = (cnt_q == CNT_W'(1));

   // R4: a loaded phase counts down and never rests above one without loading
   assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/pbus_idpack.sv
// Byte lane shifter: each shift moves lanes up one position and inserts the new byte at lane 0.
module pbus_idpack #(
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               shift,
   input  logic [7:0]         byte_in,
   output logic [8*LANES-1:0] value
);
   if (LANES < 1) begin : g_bad_lanes
      $error("pbus_idpack: LANES must be at least 1");
   end

   logic [7:0] lane_q [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n || clr) lane_q[i] <= '0;
            else if (shift)    lane_q[i] <= byte_in;
         end
      end else begin : g_rest
         always_ff @(posedge clk) begin
            if (!rst_n || clr) lane_q[i] <= '0;
            else if (shift)    lane_q[i] <= lane_q[i-1];
         end
      end
      assign value[8*i +: 8] = lane_q[i];
   end

   // R6: a shift places the new byte in the lowest lane
   assert_low_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !clr) |=> (value[7:0] == $past(byte_in)));
endmodule

// File: rtl/pbus_host.sv
module pbus_host
   import pbus_pkg::*;
#(
   parameter int                BUS_W            = 16,
   parameter int                CMD_W            = 8,
   parameter int                CNT_W            = 4,
   parameter int                MAX_ID_BYTES     = 4,
   parameter int                ID_DEFAULT_BYTES = 3,
   parameter logic [CMD_W-1:0]  ID_CMD           = 8'h04,
   parameter logic [31:0]       ID_ABSENT        = 32'h0004_0404,
   localparam int               ID_W             = 8 * MAX_ID_BYTES,
   localparam int               NB_W             = $clog2(MAX_ID_BYTES + 1),
   localparam int               STEP_W           = $clog2(MAX_ID_BYTES + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [BUS_W-1:0]  req_wdata,
   input  logic [NB_W-1:0]   req_nbytes,
   input  logic [CNT_W-1:0]  cfg_addr_setup,
   input  logic [CNT_W-1:0]  cfg_data_setup,
   output logic              busy,
   output logic              done,
   output logic [ID_W-1:0]   rd_value,
   output logic              no_display,
   output logic              lcd_cs_n,
   output logic              lcd_rs,
   output logic              lcd_wr_n,
   output logic              lcd_rd_n,
   output logic [BUS_W-1:0]  lcd_d_o,
   output logic              lcd_d_oe,
   input  logic [7:0]        lcd_d_i
);
   if (BUS_W < CMD_W || BUS_W < 8) begin : g_bad_bus
      $error("pbus_host: BUS_W must hold a command and a byte");
   end
   if (MAX_ID_BYTES < 1 || ID_DEFAULT_BYTES < 1 || ID_DEFAULT_BYTES > MAX_ID_BYTES) begin : g_bad_id
      $error("pbus_host: identification byte counts out of range");
   end

   pbus_phase_e         ph_q;
   pbus_op_e            op_q;
   pbus_op_e            req_op_e;
   logic [BUS_W-1:0]    wd_q;
   logic [STEP_W-1:0]   step_q, last_q;
   logic                done_q, nodisp_q;
   logic [NB_W-1:0]     nb_eff;
   logic                accept, is_read, t_load, t_last, pk_shift, pk_clr;
   logic [CNT_W-1:0]    t_val;
   logic [ID_W-1:0]     id_val;

   assign req_op_e = pbus_op_e'(req_op);
   assign accept   = (ph_q == PH_IDLE) && req_valid && (req_op_e != OP_RSV);
   assign nb_eff   = (req_nbytes == '0 || int'(req_nbytes) > MAX_ID_BYTES)
                     ? NB_W'(ID_DEFAULT_BYTES) : req_nbytes;
   // bus cycle 0 of an identification read is the command write; the rest are reads
   assign is_read  = (op_q == OP_ID) && (step_q != '0);

   assign t_load   = accept
                   || (ph_q == PH_SETUP && t_last)
                   || (ph_q == PH_HOLD && step_q != last_q);
   assign t_val    = (ph_q == PH_SETUP) ? cfg_data_setup : cfg_addr_setup;
   // the dummy read is bus cycle 1; packing starts with bus cycle 2
   assign pk_shift = (ph_q == PH_STROBE) && t_last && is_read && (step_q >= STEP_W'(2));
   assign pk_clr   = accept && (req_op_e == OP_ID);

   pbus_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .last     (t_last)
   );

   pbus_idpack #(.LANES(MAX_ID_BYTES)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pk_clr),
      .shift   (pk_shift),
      .byte_in (lcd_d_i),
      .value   (id_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         op_q     <= OP_CMD;
         wd_q     <= '0;
         step_q   <= '0;
         last_q   <= '0;
         done_q   <= 1'b0;
         nodisp_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: if (accept) begin
               ph_q   <= PH_SETUP;
               op_q   <= req_op_e;
               step_q <= '0;
               last_q <= (req_op_e == OP_ID) ? STEP_W'(nb_eff) + STEP_W'(1) : '0;
               unique case (req_op_e)
                  OP_DATA: wd_q <= req_wdata;
                  OP_ID:   wd_q <= BUS_W'(ID_CMD);
                  default: wd_q <= BUS_W'(req_wdata[CMD_W-1:0]);
               endcase
            end
            PH_SETUP:  if (t_last) ph_q <= PH_STROBE;
            PH_STROBE: if (t_last) ph_q <= PH_HOLD;
            PH_HOLD: begin
               if (step_q == last_q) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
                  if (op_q == OP_ID) nodisp_q <= (id_val == ID_W'(ID_ABSENT));
               end else begin
                  step_q <= step_q + STEP_W'(1);
                  ph_q   <= PH_SETUP;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy       = (ph_q != PH_IDLE);
   assign done       = done_q;
   assign rd_value   = id_val;
   assign no_display = nodisp_q;
   assign lcd_cs_n   = (ph_q == PH_IDLE);
   assign lcd_rs     = !(op_q == OP_CMD || (op_q == OP_ID && step_q == '0));
   assign lcd_wr_n   = !((ph_q == PH_STROBE) && !is_read);
   assign lcd_rd_n   = !((ph_q == PH_STROBE) && is_read);
   assign lcd_d_oe   = (ph_q != PH_IDLE) && !is_read;
   assign lcd_d_o    = wd_q;

   // R10: no strobe without chip select
   assert_strobe_in_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!lcd_wr_n || !lcd_rd_n) |-> !lcd_cs_n);
   // R8: bus released whenever the read strobe is low
   assert_read_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_rd_n |-> !lcd_d_oe);
   // R4: written data still driven and unchanged in the cycle the write strobe rises
   assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lcd_wr_n) && !lcd_cs_n) |-> (lcd_d_oe && $stable(lcd_d_o)));
   // R9: done is a single-cycle pulse outside the transaction
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lcd_cs_n && !busy));
   // R11: the flag moves only as an identification read completes
   assert_flag_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(no_display) |-> (done && $past(op_q == OP_ID)));
endmodule

// File: tb/sim_pbus_host.sv
`timescale 1ns/1ps
module sim_pbus_host;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [15:0] req_wdata = '0;
   logic [2:0]  req_nbytes = '0;
   logic [3:0]  cfg_a = 4'd1, cfg_d = 4'd1;
   logic        busy, done, no_display, lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_d_oe;
   logic [31:0] rd_value;
   logic [15:0] lcd_d_o;
   logic [7:0]  lcd_d_i;

   int checks = 0;
   int errors = 0;
   int d_eff  = 1;
   logic [7:0]  id_bytes [0:7];
   logic [16:0] wlog [0:7];

   always #10 clk = ~clk;

   pbus_host u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_wdata(req_wdata), .req_nbytes(req_nbytes),
      .cfg_addr_setup(cfg_a), .cfg_data_setup(cfg_d),
      .busy(busy), .done(done), .rd_value(rd_value), .no_display(no_display),
      .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
      .lcd_d_o(lcd_d_o), .lcd_d_oe(lcd_d_oe), .lcd_d_i(lcd_d_i)
   );

   // display model: true byte only on the last strobe cycle, decoy otherwise
   int rd_cnt = 0;
   int rd_idx = 0;
   logic [15:0] model_word;
   always_ff @(posedge clk) begin
      if (lcd_cs_n) rd_idx <= 0;
      if (lcd_rd_n) rd_cnt <= 0;
      else begin
         rd_cnt <= rd_cnt + 1;
         if (rd_cnt == d_eff - 1) rd_idx <= rd_idx + 1;
      end
   end
   always_comb begin
      if (!lcd_rd_n && rd_cnt == d_eff - 1)
         model_word = (rd_idx == 0) ? 16'hA577 : {8'hC0 | 8'(rd_idx), id_bytes[rd_idx[2:0]]};
      else
         model_word = 16'hBEEF;
      lcd_d_i = model_word[7:0];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_txn(input logic [1:0] op, input logic [15:0] wd, input logic [2:0] nb,
                          input bit stray, output int cyc, output int cs_lo, output int wr_lo,
                          output int rd_lo, output int oe_hi, output int nw);
      logic prev_wr;
      cyc = 0; cs_lo = 0; wr_lo = 0; rd_lo = 0; oe_hi = 0; nw = 0; prev_wr = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_wdata = wd; req_nbytes = nb;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && cyc < 5000) begin
         if (!lcd_cs_n) cs_lo++;
         if (!lcd_wr_n) wr_lo++;
         if (!lcd_rd_n) begin
            rd_lo++;
            chk(!lcd_d_oe, "R8", "bus released during read strobe", lcd_d_oe, 0);
         end
         if (lcd_d_oe) oe_hi++;
         if (!prev_wr && lcd_wr_n) begin
            chk(lcd_d_oe && !lcd_cs_n, "R4", "data driven in hold cycle", lcd_d_oe, 1);
            if (nw < 8) wlog[nw] = {lcd_rs, lcd_d_o};
            nw++;
         end
         prev_wr = lcd_wr_n;
         if (stray && cyc == 1) begin
            req_valid = 1'b1; req_op = 2'b01; req_wdata = 16'hDEAD;
         end
         if (stray && cyc == 3) req_valid = 1'b0;
         cyc++;
         @(negedge clk);
      end
      chk(done && !busy, "R9", "done with busy low", {done, busy}, 2'b10);
      @(negedge clk);
      chk(!done, "R9", "done lasts one cycle", done, 0);
   endtask

   initial begin
      #(20 * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw;
      for (int i = 0; i < 8; i++) id_bytes[i] = '0;
      repeat (3) @(negedge clk);
      chk(lcd_cs_n && lcd_wr_n && lcd_rd_n && !lcd_d_oe, "R1", "bus idle in reset",
          {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_d_oe}, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && rd_value == 0 && !no_display && lcd_cs_n, "R1", "status after reset",
          {busy, done, no_display, rd_value}, 0);

      for (int a = 0; a <= 4; a++) begin
         for (int d = 1; d <= 4; d++) begin
            int ae, unit, n, ne;
            logic [15:0] wd;
            logic [31:0] exp;
            ae = (a == 0) ? 1 : a;
            unit = ae + d + 1;
            cfg_a = 4'(a); cfg_d = 4'(d); d_eff = d;

            // command write
            wd = {8'h90 + 8'(a), 8'(16 * a + d + 3)};
            run_txn(2'b00, wd, 3'd0, 1'b0, cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw);
            chk(cyc == unit, "R4", "command busy cycles", cyc, unit);
            chk(wr_lo == d && rd_lo == 0, "R4", "command strobe length", wr_lo, d);
            chk(nw == 1 && wlog[0] == {1'b0, 8'h00, wd[7:0]}, "R2", "command on bus", wlog[0],
                {1'b0, 8'h00, wd[7:0]});

            // data write
            wd = 16'h1234 ^ 16'(a * 4099 + d * 257);
            run_txn(2'b01, wd, 3'd0, 1'b0, cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw);
            chk(cyc == unit && cs_lo == unit, "R4", "data busy cycles", cyc, unit);
            chk(nw == 1 && wlog[0] == {1'b1, wd}, "R3", "data on bus", wlog[0], {1'b1, wd});

            // identification read
            n = (a + d) % 5;
            ne = (n == 0) ? 3 : n;
            exp = '0;
            for (int i = 1; i <= 4; i++) id_bytes[i] = 8'(a * 29 + d * 13 + i * 7);
            for (int i = 1; i <= ne; i++) exp = (exp << 8) | 32'(id_bytes[i]);
            run_txn(2'b10, 16'hFFFF, 3'(n), 1'b0, cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw);
            chk(cyc == (ne + 2) * unit, "R5", "identification bus cycles", cyc, (ne + 2) * unit);
            chk(cs_lo == cyc, "R10", "chip select held over burst", cs_lo, cyc);
            chk(nw == 1 && wlog[0] == {1'b0, 16'h0004}, "R5", "identification command",
                wlog[0], {1'b0, 16'h0004});
            chk(rd_lo == (ne + 1) * d, "R5", "dummy plus data reads", rd_lo, (ne + 1) * d);
            chk(oe_hi == unit, "R8", "bus driven only for command cycle", oe_hi, unit);
            chk(rd_value == exp, "R6", "packed identification", rd_value, exp);
            if (n == 0) chk(rd_value == exp, "R7", "zero count gives three bytes", rd_value, exp);
            chk(no_display == 1'b0, "R11", "flag clear for live display", no_display, 0);
         end
      end

      // byte count above maximum, short timing
      cfg_a = 4'd2; cfg_d = 4'd2; d_eff = 2;
      id_bytes[1] = 8'h12; id_bytes[2] = 8'h34; id_bytes[3] = 8'h56; id_bytes[4] = 8'h78;
      run_txn(2'b10, 16'h0, 3'd7, 1'b0, cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw);
      chk(rd_value == 32'h0012_3456, "R7", "oversize count gives three bytes", rd_value, 32'h123456);

      // absent display pattern
      id_bytes[1] = 8'h04; id_bytes[2] = 8'h04; id_bytes[3] = 8'h04;
      run_txn(2'b10, 16'h0, 3'd3, 1'b0, cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw);
      chk(no_display && rd_value == 32'h0004_0404, "R11", "absent pattern flagged",
          {no_display, rd_value}, {1'b1, 32'h40404});
      run_txn(2'b00, 16'h0011, 3'd0, 1'b0, cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw);
      chk(no_display && rd_value == 32'h0004_0404, "R11", "write leaves flag and value",
          {no_display, rd_value}, {1'b1, 32'h40404});
      id_bytes[3] = 8'h05;
      run_txn(2'b10, 16'h0, 3'd3, 1'b0, cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw);
      chk(!no_display, "R11", "flag cleared by live read", no_display, 0);

      // request raised while busy is dropped
      run_txn(2'b01, 16'h5151, 3'd0, 1'b1, cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw);
      begin
         int started = 0;
         repeat (6) begin
            @(negedge clk);
            if (!lcd_cs_n || busy) started++;
         end
         chk(started == 0, "R9", "request during busy ignored", started, 0);
      end

      // reserved operation code
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b11; req_wdata = 16'h7777;
      @(negedge clk);
      req_valid = 1'b0;
      begin
         int started = 0;
         repeat (5) begin
            if (!lcd_cs_n || busy) started++;
            @(negedge clk);
         end
         chk(started == 0, "R12", "reserved code starts nothing", started, 0);
      end

      // common 15/15 timing
      cfg_a = 4'd15; cfg_d = 4'd15; d_eff = 15;
      run_txn(2'b00, 16'h002C, 3'd0, 1'b0, cyc, cs_lo, wr_lo, rd_lo, oe_hi, nw);
      chk(cyc == 31 && wr_lo == 15, "R4", "15/15 timing", cyc, 31);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule